// File: doc/BRIEF.md
# Host Message Queue Controller

This block is the queue side of a messaging link between a host and a local I/O processor. It has five descriptor FIFOs behind a small register-style host port. These are the request post queue, the reply free queue, the reply post queue, the high-priority post queue and the high-priority free queue. The host posts request descriptors, which are pointers to request frames of up to 128 bytes, each starting with a header that identifies the message. The host also returns reply frames it has finished with, collects completions, and trades high-priority request frames. The local processor pops posted requests from its own side, supplies free high-priority frames, and reports I/O completions.

A completion takes one of two forms. A successful I/O posts a context reply straight away. A failed I/O first takes a frame address from the reply free queue. It then writes an error word to that frame through a one-beat memory write port, and only after that posts an address reply. An interrupt-pending output tells the host that completions are waiting.

Top module: `hmq_top`

## Requirements
- R1: After reset, every queue is empty and no overflow is flagged, so the status word reads 0x0000001F. `irqPending`, `reqValid` and `hpReqValid` are low.
- R2: A host write with `hostSel`=0 pushes `hostWrData` into the request post queue. The local side sees the descriptors in arrival order on `reqData` while `reqValid` is high, and `reqPopEn` removes the head.
- R3: A host write to a full queue is dropped and sets that queue's overflow bit. The bit stays set until reset.
- R4: When a completion with `cplOk`=1 is accepted (`cplValid` and `cplReady` both high), {1'b0, `cplContext`} is pushed to the reply post queue. Bit 31 = 0 marks a context reply.
- R5: When a failing completion is accepted, the reply free head A is popped. In the next cycle `memWrEn` is high for exactly one cycle, with `memWrAddr`=A and `memWrData`=`cplErrCode`. After that, {1'b1, A[31:1]} is pushed to the reply post queue.
- R6: A failing completion finds `cplReady` low while the reply free queue is empty. `cplReady` rises once a host write with `hostSel`=1 supplies a frame address.
- R7: `hostRdData` with `hostSel`=0 shows the reply post head, and `hostRdEn` pops it. When that queue is empty, the read returns 0xFFFFFFFF and changes nothing.
- R8: A host write with `hostSel`=2 posts to the high-priority post queue, which the local side drains with `hpReqPopEn`. `hpFreePush` fills the high-priority free queue while `hpFreeReady` is high. A host read with `hostSel`=2 pops that free queue, and returns 0xFFFFFFFF when it is empty.
- R9: `irqPending` is high exactly while the reply post queue holds an entry. Only a host pop of that queue can drop it.
- R10: A host read with `hostSel`=1 returns the status word: bits 4:0 are the empty flags, bits 9:5 the full flags and bits 14:10 the overflow flags, indexed request post=0, reply free=1, reply post=2, high-priority post=3, high-priority free=4. `hostSel`=3 reads 0 and ignores writes.
- R11: `cplReady` stays low from the acceptance of a failing completion until its address reply has been posted.
- R12: A successful completion sees `cplReady` low while the reply post queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Host register select |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdEn | input | 1 | Host read strobe (pops on queue selects) |
| hostRdData | output | 32 | Host read data for the current select |
| irqPending | output | 1 | Reply post queue not empty |
| reqValid | output | 1 | Request post queue has a descriptor |
| reqData | output | 32 | Request post head |
| reqPopEn | input | 1 | Local pop of request post queue |
| hpReqValid | output | 1 | High-priority post queue has a descriptor |
| hpReqData | output | 32 | High-priority post head |
| hpReqPopEn | input | 1 | Local pop of high-priority post queue |
| hpFreePush | input | 1 | Local push of a free high-priority frame |
| hpFreeData | input | 32 | Free high-priority frame address |
| hpFreeReady | output | 1 | High-priority free queue not full |
| cplValid | input | 1 | Completion offered |
| cplOk | input | 1 | Completion succeeded |
| cplContext | input | 31 | Message context of the request |
| cplErrCode | input | 32 | Error word for a failed completion |
| cplReady | output | 1 | Completion accepted this cycle when valid |
| memWrEn | output | 1 | Error frame write strobe |
| memWrAddr | output | 32 | Error frame address |
| memWrData | output | 32 | Error word |

## Verification
The assertions watch these rules on every cycle:
- the error write follows an accepted failure by exactly one cycle and never overlaps a new acceptance;
- a failure is never accepted without a free frame;
- an empty reply read returns all ones;
- overflow flags never clear;
- the interrupt drops only on a host reply pop.

Only the bench scenarios can show the following:
- descriptor order and values through full-depth sweeps;
- the encoding of both reply formats;
- the stalls on an empty free queue and a full reply queue;
- dropped writes on full queues;
- the layout of the status word.

// File: rtl/hmq_pkg.sv
package hmq_pkg;
  localparam int NQ       = 5;
  localparam int Q_REQ    = 0;
  localparam int Q_FREE   = 1;
  localparam int Q_RPOST  = 2;
  localparam int Q_HPPOST = 3;
  localparam int Q_HPFREE = 4;

  localparam logic [1:0] SEL_MSG  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_HP   = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_POST} cplState_e;

  typedef struct packed {
    logic [NQ-1:0] push;
    logic [NQ-1:0] pop;
    logic [NQ-1:0] ovfSet;
    logic          latchFail;
    logic          memWr;
    logic          replyIsAddr;
  } strobes_t;
endpackage

// File: rtl/hmq_fifo.sv
module hmq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push && !full) wrPtr <= wrPtr + 1'b1;
      if (pop && !empty) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wrPtr[AW-1:0]] <= din;
  end

  assign empty = (wrPtr == rdPtr);
  assign full  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dout  = mem[rdPtr[AW-1:0]];
endmodule

// File: rtl/hmq_ctrl.sv
module hmq_ctrl
  import hmq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    hostSel,
  input  logic          hostWrEn,
  input  logic          hostRdEn,
  input  logic          reqPopEn,
  input  logic          hpReqPopEn,
  input  logic          hpFreePush,
  input  logic          cplValid,
  input  logic          cplOk,
  input  logic [NQ-1:0] qEmpty,
  input  logic [NQ-1:0] qFull,
  output strobes_t      stb,
  output logic          cplReady
);
  cplState_e state, nextState;
  logic [NQ-1:0] hostWrMask, hostRdMask;

  always_comb begin
    hostWrMask = '0;
    hostRdMask = '0;
    case (hostSel)
      SEL_MSG: begin
        hostWrMask[Q_REQ]   = hostWrEn;
        hostRdMask[Q_RPOST] = hostRdEn;
      end
      SEL_STAT: hostWrMask[Q_FREE] = hostWrEn;
      SEL_HP: begin
        hostWrMask[Q_HPPOST] = hostWrEn;
        hostRdMask[Q_HPFREE] = hostRdEn;
      end
      default: ;
    endcase
  end

  always_comb begin
    stb        = '0;
    nextState  = state;
    cplReady   = 1'b0;
    stb.push   = hostWrMask & ~qFull;
    stb.ovfSet = hostWrMask & qFull;
    stb.pop    = hostRdMask & ~qEmpty;
    if (reqPopEn && !qEmpty[Q_REQ])       stb.pop[Q_REQ]     = 1'b1;
    if (hpReqPopEn && !qEmpty[Q_HPPOST])  stb.pop[Q_HPPOST]  = 1'b1;
    if (hpFreePush && !qFull[Q_HPFREE])   stb.push[Q_HPFREE] = 1'b1;
    case (state)
      ST_IDLE: begin
        cplReady = cplOk ? !qFull[Q_RPOST] : !qEmpty[Q_FREE];
        if (cplValid && cplReady) begin
          if (cplOk) begin
            stb.push[Q_RPOST] = 1'b1;
          end else begin
            stb.pop[Q_FREE] = 1'b1;
            stb.latchFail   = 1'b1;
            nextState       = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        stb.memWr = 1'b1;
        nextState = ST_POST;
      end
      ST_POST: begin
        if (!qFull[Q_RPOST]) begin
          stb.push[Q_RPOST] = 1'b1;
          stb.replyIsAddr   = 1'b1;
          nextState         = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/hmq_datapath.sv
module hmq_datapath
  import hmq_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic [1:0]    hostSel,
  input  logic [W-1:0]  hostWrData,
  input  logic [W-2:0]  cplContext,
  input  logic [W-1:0]  cplErrCode,
  input  logic [W-1:0]  hpFreeData,
  output logic [NQ-1:0] qEmpty,
  output logic [NQ-1:0] qFull,
  output logic [NQ-1:0] ovfBits,
  output logic [W-1:0]  hostRdData,
  output logic [W-1:0]  reqData,
  output logic [W-1:0]  hpReqData,
  output logic          memWrEn,
  output logic [W-1:0]  memWrAddr,
  output logic [W-1:0]  memWrData
);
  localparam int STAT_W = 3 * NQ;

  logic [W-1:0] qDin  [NQ];
  logic [W-1:0] qDout [NQ];
  logic [W-1:0] failAddr, failCode, statusWord;

  always_comb begin
    qDin[Q_REQ]    = hostWrData;
    qDin[Q_FREE]   = hostWrData;
    qDin[Q_HPPOST] = hostWrData;
    qDin[Q_HPFREE] = hpFreeData;
    qDin[Q_RPOST]  = stb.replyIsAddr ? {1'b1, failAddr[W-1:1]} : {1'b0, cplContext};
  end

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    hmq_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
      .clk  (clk),
      .rstN (rstN),
      .push (stb.push[q]),
      .pop  (stb.pop[q]),
      .din  (qDin[q]),
      .dout (qDout[q]),
      .full (qFull[q]),
      .empty(qEmpty[q])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfBits  <= '0;
      failAddr <= '0;
      failCode <= '0;
    end else begin
      ovfBits <= ovfBits | stb.ovfSet;
      if (stb.latchFail) begin
        failAddr <= qDout[Q_FREE];
        failCode <= cplErrCode;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[STAT_W-1:0] = {ovfBits, qFull, qEmpty};
    case (hostSel)
      SEL_MSG:  hostRdData = qEmpty[Q_RPOST]  ? '1 : qDout[Q_RPOST];
      SEL_STAT: hostRdData = statusWord;
      SEL_HP:   hostRdData = qEmpty[Q_HPFREE] ? '1 : qDout[Q_HPFREE];
      default:  hostRdData = '0;
    endcase
  end

  assign reqData   = qDout[Q_REQ];
  assign hpReqData = qDout[Q_HPPOST];
  assign memWrEn   = stb.memWr;
  assign memWrAddr = failAddr;
  assign memWrData = failCode;
endmodule

// File: rtl/hmq_top.sv
module hmq_top
  import hmq_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   hostSel,
  input  logic         hostWrEn,
  input  logic [W-1:0] hostWrData,
  input  logic         hostRdEn,
  output logic [W-1:0] hostRdData,
  output logic         irqPending,
  output logic         reqValid,
  output logic [W-1:0] reqData,
  input  logic         reqPopEn,
  output logic         hpReqValid,
  output logic [W-1:0] hpReqData,
  input  logic         hpReqPopEn,
  input  logic         hpFreePush,
  input  logic [W-1:0] hpFreeData,
  output logic         hpFreeReady,
  input  logic         cplValid,
  input  logic         cplOk,
  input  logic [W-2:0] cplContext,
  input  logic [W-1:0] cplErrCode,
  output logic         cplReady,
  output logic         memWrEn,
  output logic [W-1:0] memWrAddr,
  output logic [W-1:0] memWrData
);
  strobes_t      stb;
  logic [NQ-1:0] qEmpty, qFull, ovfBits;

  hmq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .reqPopEn(reqPopEn), .hpReqPopEn(hpReqPopEn),
    .hpFreePush(hpFreePush), .cplValid(cplValid), .cplOk(cplOk),
    .qEmpty(qEmpty), .qFull(qFull), .stb(stb), .cplReady(cplReady)
  );

  hmq_datapath #(.W(W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostSel(hostSel),
    .hostWrData(hostWrData), .cplContext(cplContext), .cplErrCode(cplErrCode),
    .hpFreeData(hpFreeData), .qEmpty(qEmpty), .qFull(qFull), .ovfBits(ovfBits),
    .hostRdData(hostRdData), .reqData(reqData), .hpReqData(hpReqData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  assign irqPending  = !qEmpty[Q_RPOST];
  assign reqValid    = !qEmpty[Q_REQ];
  assign hpReqValid  = !qEmpty[Q_HPPOST];
  assign hpFreeReady = !qFull[Q_HPFREE];
endmodule

// File: rtl/hmq_checker.sv
module hmq_checker
  import hmq_pkg::*;
#(
  parameter int W = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [1:0]    hostSel,
  input logic          hostRdEn,
  input logic [W-1:0]  hostRdData,
  input logic          irqPending,
  input logic          cplValid,
  input logic          cplOk,
  input logic          cplReady,
  input logic          memWrEn,
  input logic          freeEmpty,
  input logic [NQ-1:0] ovfBits
);
  // R5: the error write comes one cycle after a failure is accepted
  p_mem_after_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(cplValid && cplReady && !cplOk));

  // R5: the error write lasts a single cycle
  p_mem_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

  // R11: no completion is accepted while the error write is under way
  p_busy_no_accept_r11: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !cplReady);

  // R6: a failure is never accepted without a free frame
  p_fail_needs_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && !cplOk && cplReady) |-> !freeEmpty);

  // R7: a reply read with no pending completion returns all ones
  p_empty_read_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel == SEL_MSG && !irqPending) |-> hostRdData == '1);

  // R3: overflow flags are sticky
  p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (ovfBits & $past(ovfBits)) == $past(ovfBits));

  // R9: the interrupt drops only on a host reply pop
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !(hostRdEn && hostSel == SEL_MSG)) |=> irqPending);
endmodule

bind hmq_top hmq_checker #(.W(W)) i_hmq_checker (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRdEn(hostRdEn),
  .hostRdData(hostRdData), .irqPending(irqPending), .cplValid(cplValid),
  .cplOk(cplOk), .cplReady(cplReady), .memWrEn(memWrEn),
  .freeEmpty(qEmpty[1]), .ovfBits(ovfBits)
);

// File: tb/test_hmq_top.sv
module test_hmq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostSel = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic        irqPending, reqValid, hpReqValid, hpFreeReady, cplReady, memWrEn;
  logic [31:0] reqData, hpReqData, memWrAddr, memWrData;
  logic        reqPopEn = 1'b0, hpReqPopEn = 1'b0, hpFreePush = 1'b0;
  logic [31:0] hpFreeData = '0, cplErrCode = '0;
  logic        cplValid = 1'b0, cplOk = 1'b0;
  logic [30:0] cplContext = '0;

  int total = 0;
  int bad = 0;
  logic [31:0] rq[$];
  logic [31:0] freeQ[$];

  always #4 clk = ~clk;

  hmq_top i_hmq_top (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] statW(logic [4:0] o, logic [4:0] f, logic [4:0] e);
    return {17'd0, o, f, e};
  endfunction

  task automatic hostWrite(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    hostSel = sel; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    hostSel = sel;
    #1 d = hostRdData;
    hostRdEn = 1'b1;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic doCpl(logic ok, logic [30:0] ctx, logic [31:0] code);
    logic [31:0] a;
    int n;
    @(negedge clk);
    cplValid = 1'b1; cplOk = ok; cplContext = ctx; cplErrCode = code;
    #1 n = 0;
    while (!cplReady && n < 1000) begin
      @(negedge clk); #1 n++;
    end
    @(negedge clk);
    if (ok) begin
      cplValid = 1'b0;
      rq.push_back({1'b0, ctx});
    end else begin
      a = freeQ.pop_front();
      chk("R5 memWrEn", {31'd0, memWrEn}, 32'd1);
      chk("R5 memWrAddr", memWrAddr, a);
      chk("R5 memWrData", memWrData, code);
      chk("R11 ready during write", {31'd0, cplReady}, 32'd0);
      cplValid = 1'b0;
      @(negedge clk);
      chk("R5 single write", {31'd0, memWrEn}, 32'd0);
      chk("R11 ready during post", {31'd0, cplReady}, 32'd0);
      @(negedge clk);
      rq.push_back({1'b1, a[31:1]});
    end
  endtask

  task automatic drainCheck(string tag);
    logic [31:0] v;
    while (rq.size() > 0) begin
      hostRead(2'd0, v);
      chk(tag, v, rq.pop_front());
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irqPending", {31'd0, irqPending}, 32'd0);
    chk("R1 reqValid", {31'd0, reqValid}, 32'd0);
    chk("R1 hpReqValid", {31'd0, hpReqValid}, 32'd0);
    hostRead(2'd1, v); chk("R1 status", v, statW(5'd0, 5'd0, 5'h1F));
    hostRead(2'd0, v); chk("R7 empty reply read", v, 32'hFFFF_FFFF);
    hostRead(2'd2, v); chk("R8 empty hp free read", v, 32'hFFFF_FFFF);

    // R2 / R3: fill request post queue to depth, then overflow
    for (int i = 0; i < 32; i++) hostWrite(2'd0, 32'hA500_0000 + i * 7);
    hostRead(2'd1, v); chk("R10 req full", v, statW(5'd0, 5'b00001, 5'h1E));
    hostWrite(2'd0, 32'hDEAD_BEEF);
    hostRead(2'd1, v); chk("R3 req overflow", v, statW(5'b00001, 5'b00001, 5'h1E));
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      chk("R2 reqValid", {31'd0, reqValid}, 32'd1);
      chk("R2 reqData order", reqData, 32'hA500_0000 + i * 7);
      reqPopEn = 1'b1;
    end
    @(negedge clk);
    reqPopEn = 1'b0;
    chk("R3 dropped write absent", {31'd0, reqValid}, 32'd0);

    // R6: failure stalls on empty free queue
    @(negedge clk);
    cplValid = 1'b1; cplOk = 1'b0; cplErrCode = 32'hE000_0099;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 stall ready", {31'd0, cplReady}, 32'd0);
      chk("R6 stall no write", {31'd0, memWrEn}, 32'd0);
    end
    cplValid = 1'b0;
    hostWrite(2'd1, 32'h1000_0000);
    freeQ.push_back(32'h1000_0000);
    cplValid = 1'b1;
    #1 chk("R6 ready after free", {31'd0, cplReady}, 32'd1);
    cplValid = 1'b0;
    doCpl(1'b0, 31'd0, 32'hE000_0001);
    chk("R9 irq after address reply", {31'd0, irqPending}, 32'd1);
    drainCheck("R5 address reply");

    // R4 / R5 mixed sweep
    for (int i = 0; i < 8; i++) begin
      hostWrite(2'd1, 32'h2000_0000 + i * 128);
      freeQ.push_back(32'h2000_0000 + i * 128);
    end
    for (int i = 0; i < 16; i++)
      doCpl((i % 3) != 0, 31'(i * 32'h111 + 5), 32'hE000_0000 | i);
    chk("R9 irq pending", {31'd0, irqPending}, 32'd1);
    drainCheck("R4 R5 reply sweep");
    @(negedge clk);
    chk("R9 irq drained", {31'd0, irqPending}, 32'd0);
    hostRead(2'd0, v); chk("R7 empty read 1", v, 32'hFFFF_FFFF);
    hostRead(2'd0, v); chk("R7 empty read 2", v, 32'hFFFF_FFFF);

    // R12: full reply post queue stalls success
    for (int i = 0; i < 32; i++) doCpl(1'b1, 31'(i + 1), 32'd0);
    hostRead(2'd1, v); chk("R10 reply full", v, statW(5'b00001, 5'b00100, 5'h19));
    @(negedge clk);
    cplValid = 1'b1; cplOk = 1'b1; cplContext = 31'd77;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 stall ready", {31'd0, cplReady}, 32'd0);
    end
    cplValid = 1'b0;
    hostRead(2'd0, v); chk("R12 first reply", v, rq.pop_front());
    doCpl(1'b1, 31'd77, 32'd0);
    drainCheck("R12 reply drain");

    // R8: high-priority queues
    for (int i = 0; i < 3; i++) hostWrite(2'd2, 32'h7000_0000 + i);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 hpReqValid", {31'd0, hpReqValid}, 32'd1);
      chk("R8 hpReqData", hpReqData, 32'h7000_0000 + i);
      hpReqPopEn = 1'b1;
    end
    @(negedge clk);
    hpReqPopEn = 1'b0;
    chk("R8 hp post drained", {31'd0, hpReqValid}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 hpFreeReady", {31'd0, hpFreeReady}, 32'd1);
      hpFreePush = 1'b1; hpFreeData = 32'h6000_0000 + i * 128;
    end
    @(negedge clk);
    hpFreePush = 1'b0;
    for (int i = 0; i < 3; i++) begin
      hostRead(2'd2, v); chk("R8 hp free read", v, 32'h6000_0000 + i * 128);
    end
    hostRead(2'd2, v); chk("R8 hp free empty", v, 32'hFFFF_FFFF);

    // R3 / R10: overflow on reply free queue, reserved select
    for (int i = 0; i < 30; i++) hostWrite(2'd1, 32'h3000_0000 + i * 128);
    hostWrite(2'd1, 32'h3FFF_0000);
    hostRead(2'd1, v); chk("R3 free overflow", v, statW(5'b00011, 5'b00010, 5'h1D));
    hostWrite(2'd3, 32'h1234_5678);
    hostRead(2'd3, v); chk("R10 reserved read", v, 32'd0);
    hostRead(2'd1, v); chk("R10 reserved write ignored", v, statW(5'b00011, 5'b00010, 5'h1D));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule